// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block works out, one clock at a time, which column a synchronous DRAM burst touches and when the matching read data is due. A controller or a memory model gives it a start pulse with the first column (8 bits). The same pulse carries the burst length code, the ordering choice (linear wrap or XOR), the access direction and the CAS latency. The block then registers one column per clock and raises a beat-valid flag with each. For read beats it raises a second flag exactly CAS-latency clocks later, when the data is due.

The start pulse captures the whole burst configuration, so the inputs may change freely while the burst runs. A full-page burst has no natural end. It walks through all 256 columns, wraps, and stops only when the terminate input is raised. The terminate input also cuts any fixed-length burst short. A single-write option limits writes to one beat while reads keep the programmed length. A new start pulse always takes over from whatever is running.

Top module: `sdram_burst_addr_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `beat_valid_o` and `rd_valid_o` are low after that edge and `col_o` is 0.
- R2: When `start_i` is high at an edge, the cycle after it shows `beat_valid_o` high with `col_o` equal to the sampled `start_col_i`. Further beats of the burst follow on consecutive cycles with no gaps.
- R3: `bl_code_i` values 0, 1, 2 and 3 select bursts of 1, 2, 4 and 8 beats. Any value from 4 to 7 selects full-page mode.
- R4: With `interleave_i` = 0 and burst length BL, beat k has column `(S & ~(BL-1)) | ((S + k) mod BL)`, where S is the start column. The upper bits stay fixed and the low log2(BL) bits count up and wrap.
- R5: With `interleave_i` = 1 and a fixed burst length, beat k has column S XOR k.
- R6: A burst length of 1 yields exactly one valid beat, in either ordering.
- R7: In full-page mode, beat k has column (S + k) mod 256 whatever `interleave_i` is, so the count wraps from 255 to 0. Beats continue until the burst is terminated or restarted.
- R8: If `term_i` is high and `start_i` is low at an edge, the beat showing before that edge is the last one, and `beat_valid_o` is low after the edge. `term_i` has no effect when no burst is running. When `start_i` and `term_i` are high at the same edge, the start wins.
- R9: When `is_write_i` and `single_wr_i` are both high at the start, the burst has exactly one beat whatever the length code. Reads, and writes with `single_wr_i` low, use the programmed length.
- R10: A read beat shown in cycle t makes `rd_valid_o` high in cycle t+L. L is the `cas_lat_i` value sampled at that burst's start: 2 or 3, with 0 or 1 treated as 2. Write beats never raise `rd_valid_o`. `rd_valid_o` is low in every other cycle.
- R11: A start pulse that arrives while a burst is running drops the old burst's remaining beats. The new burst's first beat appears on the next cycle, and the read beats already shown still raise their `rd_valid_o` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a burst; the fields below are captured on this edge |
| start_col_i | input | 8 | First column of the burst |
| bl_code_i | input | 3 | Burst length: 0=1, 1=2, 2=4, 3=8, 4..7=full page |
| interleave_i | input | 1 | 1 selects XOR ordering, 0 linear wrap |
| is_write_i | input | 1 | 1 for a write burst, 0 for a read burst |
| single_wr_i | input | 1 | 1 limits write bursts to one beat |
| cas_lat_i | input | 2 | Read latency in clocks (2 or 3) |
| term_i | input | 1 | End the running burst after the current beat |
| beat_valid_o | output | 1 | A burst beat is presented this cycle |
| col_o | output | 8 | Column of the current beat |
| rd_valid_o | output | 1 | Read data for an earlier beat is due this cycle |

## Verification
The checker watches these rules on every cycle: the reset state, the first column after a start, a prompt stop after terminate, a single beat for length-1 bursts and for single-beat writes, and the rule that a read-valid pulse always follows a beat by 2 or 3 cycles. The bench's cycle model alone checks the column order in both modes, the length decoding, full-page wrap past column 255, and a restart in the middle of a burst. It also checks that overlapping read-valid pulses from back-to-back bursts with different latencies land exactly where they should.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int LAT_W = 2;
  localparam int LG_W  = 3;

  typedef logic [LAT_W-1:0] lat_t;

  typedef enum logic {ORD_LINEAR = 1'b0, ORD_XOR = 1'b1} order_e;

  typedef struct packed {
    logic            full;
    logic [LG_W-1:0] len_lg;
    order_e          order;
    logic            is_rd;
    lat_t            lat;
  } burst_cfg_t;
endpackage

// File: rtl/burst_cfg_decode.sv
module burst_cfg_decode
  import burst_pkg::*;
#(
  parameter int CL_MIN = 2,
  parameter int CL_MAX = 3
) (
  input  logic [2:0] bl_code_i,
  input  logic       interleave_i,
  input  logic       is_write_i,
  input  logic       single_wr_i,
  input  lat_t       cas_lat_i,
  output burst_cfg_t cfg_o
);
  logic one_beat_wr;

  always_comb begin
    one_beat_wr  = is_write_i && single_wr_i;
    cfg_o.full   = bl_code_i[2] && !one_beat_wr;
    cfg_o.len_lg = (one_beat_wr || bl_code_i[2]) ? '0 : LG_W'({1'b0, bl_code_i[1:0]});
    cfg_o.order  = interleave_i ? ORD_XOR : ORD_LINEAR;
    cfg_o.is_rd  = !is_write_i;
    if (cas_lat_i < lat_t'(CL_MIN))      cfg_o.lat = lat_t'(CL_MIN);
    else if (cas_lat_i > lat_t'(CL_MAX)) cfg_o.lat = lat_t'(CL_MAX);
    else                                 cfg_o.lat = cas_lat_i;
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  burst_cfg_t       cfg_i,
  input  logic             term_i,
  output logic             beat_valid_o,
  output logic [COL_W-1:0] col_o,
  output logic             beat_rd_o,
  output lat_t             beat_lat_o
);
  burst_cfg_t       run_cfg;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] idx_q;
  logic [COL_W-1:0] nxt_idx;
  logic [COL_W-1:0] mask_c;
  logic [COL_W-1:0] nxt_col;
  logic             more;

  always_comb begin
    for (int b = 0; b < COL_W; b++) begin
      mask_c[b] = (b < int'(run_cfg.len_lg));
    end
    nxt_idx = idx_q + COL_W'(1);
    more    = run_cfg.full || ((nxt_idx & ~mask_c) == '0);
    if (run_cfg.full)
      nxt_col = base_q + nxt_idx;
    else if (run_cfg.order == ORD_XOR)
      nxt_col = base_q ^ nxt_idx;
    else
      nxt_col = (base_q & ~mask_c) | ((base_q + nxt_idx) & mask_c);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cfg      <= '0;
      base_q       <= '0;
      idx_q        <= '0;
      col_o        <= '0;
      beat_valid_o <= 1'b0;
    end else if (start_i) begin
      run_cfg      <= cfg_i;
      base_q       <= start_col_i;
      idx_q        <= '0;
      col_o        <= start_col_i;
      beat_valid_o <= 1'b1;
    end else if (beat_valid_o && !term_i && more) begin
      idx_q        <= nxt_idx;
      col_o        <= nxt_col;
      beat_valid_o <= 1'b1;
    end else begin
      beat_valid_o <= 1'b0;
    end
  end

  assign beat_rd_o  = run_cfg.is_rd;
  assign beat_lat_o = run_cfg.lat;
endmodule

// File: rtl/rd_valid_pipe.sv
module rd_valid_pipe
  import burst_pkg::*;
#(
  parameter int CL_MAX = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic beat_valid_i,
  input  logic beat_rd_i,
  input  lat_t beat_lat_i,
  output logic rd_valid_o
);
  localparam int NSTG = (CL_MAX > 2) ? CL_MAX - 1 : 1;

  logic [NSTG-1:0] v_q;
  lat_t            lat_q [NSTG];
  logic [NSTG-1:0] hit;

  for (genvar s = 0; s < NSTG; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) begin
          v_q[s]   <= 1'b0;
          lat_q[s] <= '0;
        end else begin
          v_q[s]   <= beat_valid_i && beat_rd_i;
          lat_q[s] <= beat_lat_i;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (rst) begin
          v_q[s]   <= 1'b0;
          lat_q[s] <= '0;
        end else begin
          v_q[s]   <= v_q[s-1];
          lat_q[s] <= lat_q[s-1];
        end
      end
    end
    assign hit[s] = v_q[s] && (lat_q[s] == lat_t'(s + 2));
  end

  always_ff @(posedge clk) begin
    if (rst) rd_valid_o <= 1'b0;
    else     rd_valid_o <= |hit;
  end
endmodule

// File: rtl/sdram_burst_addr_gen.sv
module sdram_burst_addr_gen
  import burst_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int CL_MIN = 2,
  parameter int CL_MAX = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       bl_code_i,
  input  logic             interleave_i,
  input  logic             is_write_i,
  input  logic             single_wr_i,
  input  logic [LAT_W-1:0] cas_lat_i,
  input  logic             term_i,
  output logic             beat_valid_o,
  output logic [COL_W-1:0] col_o,
  output logic             rd_valid_o
);
  burst_cfg_t cfg;
  logic       beat_rd;
  lat_t       beat_lat;

  burst_cfg_decode #(.CL_MIN(CL_MIN), .CL_MAX(CL_MAX)) u_dec (
    .bl_code_i   (bl_code_i),
    .interleave_i(interleave_i),
    .is_write_i  (is_write_i),
    .single_wr_i (single_wr_i),
    .cas_lat_i   (cas_lat_i),
    .cfg_o       (cfg)
  );

  burst_col_seq #(.COL_W(COL_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .cfg_i       (cfg),
    .term_i      (term_i),
    .beat_valid_o(beat_valid_o),
    .col_o       (col_o),
    .beat_rd_o   (beat_rd),
    .beat_lat_o  (beat_lat)
  );

  rd_valid_pipe #(.CL_MAX(CL_MAX)) u_rdp (
    .clk         (clk),
    .rst         (rst),
    .beat_valid_i(beat_valid_o),
    .beat_rd_i   (beat_rd),
    .beat_lat_i  (beat_lat),
    .rd_valid_o  (rd_valid_o)
  );
endmodule

// File: rtl/burst_addr_checker.sv
module burst_addr_checker (
  input logic       clk,
  input logic       rst,
  input logic       start_i,
  input logic [7:0] start_col_i,
  input logic [2:0] bl_code_i,
  input logic       is_write_i,
  input logic       single_wr_i,
  input logic       term_i,
  input logic       beat_valid_o,
  input logic [7:0] col_o,
  input logic       rd_valid_o
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!beat_valid_o && !rd_valid_o && col_o == 8'd0));

  p_first_col_r2: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (beat_valid_o && col_o == $past(start_col_i)));

  p_len_one_r6: assert property (@(posedge clk) disable iff (rst)
    (start_i && bl_code_i == 3'd0) ##1 !start_i |=> !beat_valid_o);

  p_term_stops_r8: assert property (@(posedge clk) disable iff (rst)
    (term_i && !start_i) |=> !beat_valid_o);

  p_single_write_r9: assert property (@(posedge clk) disable iff (rst)
    (start_i && is_write_i && single_wr_i) ##1 !start_i |=> !beat_valid_o);

  p_rd_follows_beat_r10: assert property (@(posedge clk) disable iff (rst)
    rd_valid_o |-> ($past(beat_valid_o, 2) || $past(beat_valid_o, 3)));
endmodule

bind sdram_burst_addr_gen burst_addr_checker u_chk (.*);

// File: tb/tb_sdram_burst_addr_gen.sv
module tb_sdram_burst_addr_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [7:0] start_col_i = '0;
  logic [2:0] bl_code_i = '0;
  logic       interleave_i = 1'b0;
  logic       is_write_i = 1'b0;
  logic       single_wr_i = 1'b0;
  logic [1:0] cas_lat_i = 2'd2;
  logic       term_i = 1'b0;
  logic       beat_valid_o;
  logic [7:0] col_o;
  logic       rd_valid_o;

  int    n_checks = 0;
  int    n_errors = 0;
  string cur_req  = "R1";
  bit    checking = 0;

  int m_bv = 0, m_col = 0, m_idx = 0, m_len = 1, m_full = 0, m_xor = 0;
  int m_base = 0, m_rd = 0, m_lat = 2, m_rdv = 0;
  int fut[8];

  always #2 clk = ~clk;

  sdram_burst_addr_gen dut (.*);

  function automatic int ref_col(int base, int idx, int len, int full, int xr);
    if (full != 0) return (base + idx) % 256;
    if (xr != 0)   return base ^ idx;
    return ((base & ~(len - 1)) | ((base + idx) & (len - 1))) & 255;
  endfunction

  always @(posedge clk) begin
    for (int k = 0; k < 7; k++) fut[k] = fut[k+1];
    fut[7] = 0;
    if (rst) begin
      m_bv = 0; m_col = 0; m_idx = 0;
      for (int k = 0; k < 8; k++) fut[k] = 0;
    end else begin
      if (start_i) begin
        m_base = int'(start_col_i);
        m_full = (bl_code_i >= 3'd4) ? 1 : 0;
        m_len  = (bl_code_i >= 3'd4) ? 256 : (1 << int'(bl_code_i));
        if (is_write_i && single_wr_i) begin m_full = 0; m_len = 1; end
        m_xor = int'(interleave_i);
        m_rd  = is_write_i ? 0 : 1;
        m_lat = (cas_lat_i < 2'd2) ? 2 : int'(cas_lat_i);
        m_idx = 0; m_bv = 1; m_col = m_base;
      end else if (m_bv != 0 && !term_i && (m_full != 0 || m_idx + 1 < m_len)) begin
        m_idx = (m_idx + 1) % 256;
        m_col = ref_col(m_base, m_idx, m_len, m_full, m_xor);
      end else begin
        m_bv = 0;
      end
      if (m_bv != 0 && m_rd != 0) fut[m_lat] = 1;
    end
    m_rdv = fut[0];
  end

  always @(negedge clk) begin
    if (checking) begin
      n_checks++;
      if (int'(beat_valid_o) != m_bv) begin
        n_errors++;
        $display("FAIL %s beat_valid: actual %0d expected %0d at %0t", cur_req, beat_valid_o, m_bv, $time);
      end
      n_checks++;
      if (int'(rd_valid_o) != m_rdv) begin
        n_errors++;
        $display("FAIL %s rd_valid: actual %0d expected %0d at %0t", cur_req, rd_valid_o, m_rdv, $time);
      end
      if (m_bv != 0) begin
        n_checks++;
        if (int'(col_o) != m_col) begin
          n_errors++;
          $display("FAIL %s col: actual %0h expected %0h at %0t", cur_req, col_o, m_col, $time);
        end
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go(int col, int bl, bit xr, bit wr, bit sw, int lat);
    @(negedge clk);
    start_i = 1'b1; start_col_i = 8'(col); bl_code_i = 3'(bl);
    interleave_i = xr; is_write_i = wr; single_wr_i = sw; cas_lat_i = 2'(lat);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic pulse_term();
    term_i = 1'b1;
    @(negedge clk);
    term_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    $display("FAIL R2 watchdog: actual still running, expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    n_checks++;
    if (beat_valid_o !== 1'b0 || rd_valid_o !== 1'b0 || col_o !== 8'd0) begin
      n_errors++;
      $display("FAIL R1 reset state: actual bv=%0b rd=%0b col=%0h expected 0 0 0", beat_valid_o, rd_valid_o, col_o);
    end
    rst = 1'b0;
    checking = 1;
    idle(2);

    cur_req = "R2 R4"; go(8'h2D, 3, 0, 0, 0, 2); idle(10);
    cur_req = "R4";    go(8'h13, 2, 0, 0, 0, 3); idle(8);
    cur_req = "R3";    go(8'hFF, 1, 0, 0, 0, 2); idle(6);
    cur_req = "R5";    go(8'h2D, 3, 1, 0, 0, 3); idle(12);
    cur_req = "R5";    go(8'h46, 2, 1, 0, 0, 2); idle(8);
    cur_req = "R6";    go(8'h77, 0, 0, 0, 0, 2); idle(5);
    cur_req = "R6";    go(8'h78, 0, 1, 0, 0, 3); idle(5);
    cur_req = "R7";    go(8'hF0, 4, 1, 0, 0, 2); idle(20); pulse_term(); idle(6);
    cur_req = "R7";    go(8'h05, 7, 0, 0, 0, 3); idle(300); pulse_term(); idle(6);
    cur_req = "R8";    go(8'h30, 3, 0, 0, 0, 2); idle(2); pulse_term(); idle(6);
    cur_req = "R8";    pulse_term(); idle(3);
    cur_req = "R8";    go(8'h40, 3, 0, 0, 0, 2); idle(1);
    term_i = 1'b1; go(8'h91, 2, 1, 0, 0, 3); term_i = 1'b0; idle(8);
    cur_req = "R9";    go(8'h50, 3, 0, 1, 1, 2); idle(6);
    cur_req = "R9";    go(8'h54, 2, 0, 0, 1, 2); idle(8);
    cur_req = "R9";    go(8'h58, 2, 0, 1, 0, 3); idle(8);
    cur_req = "R9";    go(8'h60, 5, 0, 1, 1, 2); idle(6);
    cur_req = "R10";   go(8'h10, 1, 0, 0, 0, 3); go(8'h20, 1, 0, 0, 0, 2); idle(8);
    cur_req = "R10";   go(8'h33, 2, 0, 0, 0, 0); idle(8);
    cur_req = "R11";   go(8'hA0, 3, 0, 0, 0, 3); idle(2); go(8'hC3, 3, 1, 0, 0, 2); idle(12);
    cur_req = "R11";   go(8'hE0, 5, 0, 0, 0, 2); idle(4); go(8'h0A, 2, 0, 1, 0, 2); idle(8);
    cur_req = "R1";
    rst = 1'b1; idle(2);
    checking = 0;
    n_checks++;
    if (beat_valid_o !== 1'b0 || rd_valid_o !== 1'b0 || col_o !== 8'd0) begin
      n_errors++;
      $display("FAIL R1 second reset: actual bv=%0b rd=%0b col=%0h expected 0 0 0", beat_valid_o, rd_valid_o, col_o);
    end
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule